// File: doc/BRIEF.md
# Dual-Clock Gray-Pointer FIFO

This block carries data words from a producer running on one clock to a consumer running on another clock that has no fixed relation to the first. Words sit in a small register array. The array has a write port clocked by the producer's clock and a read port clocked by the consumer's clock. The producer offers a word by raising its write enable. The word is taken on that write-clock edge unless the buffer reports that it has no free space. The consumer raises its read enable to take the oldest word. That word appears on the read data output after the read-clock edge, unless the buffer reports that it holds nothing.

Each side keeps its own position counter, one bit wider than the array address. The write side keeps the head, which is the slot for the next word written. The read side keeps the tail, which is the slot for the next word read. Each counter is registered in a reflected-binary (Gray) form, so that only one bit changes per step. That form is carried into the other clock domain through a chain of flip-flops and then turned back into binary. The "no space" and "nothing held" flags come from comparing a local binary counter with the converted copy of the far counter.

The copy of the far counter always lags the real value. Because of this, each flag can only be late to clear and is never early to clear. The array depth, word width and synchronizer length are parameters. Elaboration rejects values that make no sense.

Top module: `gfifo_top`

## Requirements
- R1: While the resets are applied and on leaving reset, `empty` is 1 and `full` is 0.
- R2: Words leave in exactly the order they were accepted, with none lost or repeated, when the write and read enables toggle irregularly on clocks of unrelated periods.
- R3: With no reads, `full` is 1 right after the write-clock edge that accepts the 2^ADDR_W-th word (8 by default). A write attempted while `full` is 1 is dropped: the head does not move, and the stored words read back unchanged.
- R4: A read attempted while `empty` is 1 is dropped: the tail does not move, `rd_data` keeps its value, and the next word written is the next word read.
- R5: `rd_data` is registered. It shows the accepted word just after the read-clock edge at which `rd_en` was 1 and `empty` was 0.
- R6: Each registered Gray pointer changes in at most one bit per clock of its own domain.
- R7: The flags are pessimistic. After a word is written into an empty buffer, `empty` stays 1 until the far pointer copy has passed through the synchronizer, which takes at least SYNC_STAGES read-clock edges. `empty` returns to 1 right after the read edge that removes the last word.
- R8: Once the buffer is drained from full, `full` returns to 0 within a bounded number of write clocks.
- R9: A write accepted while `full` is 0 advances the head by exactly one. A read accepted while `empty` is 0 advances the tail by exactly one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain asynchronous reset, active low |
| wr_en | input | 1 | Request to store `wr_data` on this write edge |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No free slot; writes are dropped |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Read-domain asynchronous reset, active low |
| rd_en | input | 1 | Request to take the oldest word on this read edge |
| rd_data | output | DATA_W | Registered output word |
| empty | output | 1 | No word held; reads are dropped |

## Verification
The checker watches four properties on every clock of each domain: that each Gray pointer moves by at most one bit, that an accepted transfer moves its pointer by exactly one, that a blocked write or read leaves its pointer (and the output word) untouched, and that the flags have their idle values on leaving reset. The bench scenarios show what a per-domain property cannot show. These are the end-to-end ordering of words across the two clocks, the exact edge at which `full` and `empty` assert, the synchronizer delay before `empty` clears, and `full` clearing after a drain.

// File: rtl/gfifo_pkg.sv
package gfifo_pkg;
   localparam int unsigned GF_MIN_SYNC = 2;
   localparam int unsigned GF_MAX_ADDR = 12;

   function automatic bit gf_params_ok(input int unsigned addr_w,
                                       input int unsigned data_w,
                                       input int unsigned sync_n);
      return (addr_w >= 1) && (addr_w <= GF_MAX_ADDR) &&
             (data_w >= 1) && (sync_n >= GF_MIN_SYNC);
   endfunction
endpackage

// File: rtl/gfifo_gray2bin.sv
module gfifo_gray2bin #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] gray,
   output logic [W-1:0] bin
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      assign bin[i] = ^gray[W-1:i];
   end
endmodule

// File: rtl/gfifo_sync.sv
module gfifo_sync #(
   parameter int unsigned W      = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gfifo_wr_ctl.sv
module gfifo_wr_ctl #(
   parameter int unsigned ADDR_W = 3,
   localparam int unsigned PTR_W = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  rgray_s,
   output logic              full,
   output logic              wr_fire,
   output logic [ADDR_W-1:0] waddr,
   output logic [PTR_W-1:0]  wbin_q,
   output logic [PTR_W-1:0]  wgray_q
);
   logic [PTR_W-1:0] rbin_s;
   logic [PTR_W-1:0] wbin_nx;

   gfifo_gray2bin #(.W(PTR_W)) u_g2b (.gray(rgray_s), .bin(rbin_s));

   // Full: wrap bits differ, slot bits equal.
   assign full    = (wbin_q[ADDR_W] != rbin_s[ADDR_W]) &&
                    (wbin_q[ADDR_W-1:0] == rbin_s[ADDR_W-1:0]);
   assign wr_fire = wr_en && !full;
   assign wbin_nx = wbin_q + PTR_W'(1);
   assign waddr   = wbin_q[ADDR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin_q  <= '0;
         wgray_q <= '0;
      end else if (wr_fire) begin
         wbin_q  <= wbin_nx;
         wgray_q <= wbin_nx ^ (wbin_nx >> 1);
      end
   end
endmodule

// File: rtl/gfifo_rd_ctl.sv
module gfifo_rd_ctl #(
   parameter int unsigned ADDR_W = 3,
   localparam int unsigned PTR_W = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [PTR_W-1:0]  wgray_s,
   output logic              empty,
   output logic              rd_fire,
   output logic [ADDR_W-1:0] raddr,
   output logic [PTR_W-1:0]  rbin_q,
   output logic [PTR_W-1:0]  rgray_q
);
   logic [PTR_W-1:0] wbin_s;
   logic [PTR_W-1:0] rbin_nx;

   gfifo_gray2bin #(.W(PTR_W)) u_g2b (.gray(wgray_s), .bin(wbin_s));

   assign empty   = (rbin_q == wbin_s);
   assign rd_fire = rd_en && !empty;
   assign rbin_nx = rbin_q + PTR_W'(1);
   assign raddr   = rbin_q[ADDR_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin_q  <= '0;
         rgray_q <= '0;
      end else if (rd_fire) begin
         rbin_q  <= rbin_nx;
         rgray_q <= rbin_nx ^ (rbin_nx >> 1);
      end
   end
endmodule

// File: rtl/gfifo_mem.sv
module gfifo_mem #(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned ADDR_W   = 3,
   parameter bit          RD_RESET = 1'b1,
   localparam int unsigned DEPTH   = 1 << ADDR_W
) (
   input  logic              wr_clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_clk,
   input  logic              rd_rst_n,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge wr_clk) begin
      if (we) store[waddr] <= wdata;
   end

   if (RD_RESET) begin : g_rd_rst
      always_ff @(posedge rd_clk or negedge rd_rst_n) begin
         if (!rd_rst_n) rdata <= '0;
         else if (re)   rdata <= store[raddr];
      end
   end else begin : g_rd_plain
      always_ff @(posedge rd_clk) begin
         if (re) rdata <= store[raddr];
      end
   end
endmodule

// File: rtl/gfifo_top.sv
module gfifo_top #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          RD_RESET    = 1'b1
) (
   input  logic              wr_clk,
   input  logic              wr_rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              full,
   input  logic              rd_clk,
   input  logic              rd_rst_n,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty
);
   import gfifo_pkg::*;

   localparam int unsigned PTR_W = ADDR_W + 1;

   if (!gf_params_ok(ADDR_W, DATA_W, SYNC_STAGES)) begin : g_bad_params
      $error("gfifo_top: illegal ADDR_W/DATA_W/SYNC_STAGES");
   end

   logic [PTR_W-1:0]  wbin_q, wgray_q, rbin_q, rgray_q;
   logic [PTR_W-1:0]  wgray_s, rgray_s;
   logic [ADDR_W-1:0] waddr, raddr;
   logic              wr_fire, rd_fire;

   gfifo_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
      .clk(wr_clk), .rst_n(wr_rst_n), .wr_en(wr_en), .rgray_s(rgray_s),
      .full(full), .wr_fire(wr_fire), .waddr(waddr),
      .wbin_q(wbin_q), .wgray_q(wgray_q)
   );

   gfifo_rd_ctl #(.ADDR_W(ADDR_W)) u_rd (
      .clk(rd_clk), .rst_n(rd_rst_n), .rd_en(rd_en), .wgray_s(wgray_s),
      .empty(empty), .rd_fire(rd_fire), .raddr(raddr),
      .rbin_q(rbin_q), .rgray_q(rgray_q)
   );

   gfifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray_q), .q(wgray_s)
   );

   gfifo_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray_q), .q(rgray_s)
   );

   gfifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RD_RESET(RD_RESET)) u_mem (
      .wr_clk(wr_clk), .we(wr_fire), .waddr(waddr), .wdata(wr_data),
      .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .re(rd_fire), .raddr(raddr),
      .rdata(rd_data)
   );
endmodule

// File: rtl/gfifo_chk.sv
module gfifo_chk #(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned DATA_W = 8,
   localparam int unsigned PTR_W = ADDR_W + 1
) (
   input logic              wr_clk,
   input logic              wr_rst_n,
   input logic              wr_en,
   input logic              full,
   input logic [PTR_W-1:0]  wbin,
   input logic [PTR_W-1:0]  wgray,
   input logic              rd_clk,
   input logic              rd_rst_n,
   input logic              rd_en,
   input logic              empty,
   input logic [PTR_W-1:0]  rbin,
   input logic [PTR_W-1:0]  rgray,
   input logic [DATA_W-1:0] rd_data
);
   p_full_idle_r1: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      $rose(wr_rst_n) |-> !full);

   p_empty_idle_r1: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      $rose(rd_rst_n) |-> empty);

   p_wgray_step_r6: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      $countones(wgray ^ $past(wgray)) <= 1);

   p_rgray_step_r6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      $countones(rgray ^ $past(rgray)) <= 1);

   p_no_overflow_r3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      (wr_en && full) |=> $stable(wbin));

   p_no_underflow_r4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (rd_en && empty) |=> ($stable(rbin) && $stable(rd_data)));

   p_wr_advance_r9: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
      (wr_en && !full) |=> (wbin == PTR_W'($past(wbin) + 1'b1)));

   p_rd_advance_r9: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
      (rd_en && !empty) |=> (rbin == PTR_W'($past(rbin) + 1'b1)));
endmodule

bind gfifo_top gfifo_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
   .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .full(full),
   .wbin(wbin_q), .wgray(wgray_q),
   .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .empty(empty),
   .rbin(rbin_q), .rgray(rgray_q), .rd_data(rd_data)
);

// File: tb/gfifo_tb.sv
module gfifo_top_tb_top;
   localparam int WR_PERIOD = 10;
   localparam int RD_PERIOD = 14;
   localparam int DATA_W    = 8;
   localparam int ADDR_W    = 3;
   localparam int DEPTH     = 1 << ADDR_W;
   localparam int N_RAND    = 200;

   logic              wr_clk = 1'b0, rd_clk = 1'b0;
   logic              wr_rst_n = 1'b0, rd_rst_n = 1'b0;
   logic              wr_en = 1'b0, rd_en = 1'b0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [DATA_W-1:0] rd_data;
   logic              full, empty;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;
   logic [DATA_W-1:0] refq [$];

   always #(WR_PERIOD/2) wr_clk = ~wr_clk;
   always #(RD_PERIOD/2) rd_clk = ~rd_clk;

   gfifo_top #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut_i (
      .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .full(full), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en),
      .rd_data(rd_data), .empty(empty)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic push(input logic [DATA_W-1:0] d);
      @(negedge wr_clk);
      while (full) @(negedge wr_clk);
      wr_en = 1'b1; wr_data = d;
      refq.push_back(d);
      @(negedge wr_clk);
      wr_en = 1'b0;
   endtask

   task automatic pop(input string req);
      logic [DATA_W-1:0] exp;
      @(negedge rd_clk);
      while (empty) @(negedge rd_clk);
      rd_en = 1'b1;
      @(negedge rd_clk);
      rd_en = 1'b0;
      exp = refq.pop_front();
      check(rd_data == exp, req, "read word", int'(rd_data), int'(exp));
   endtask

   task automatic t_reset();
      repeat (3) @(negedge wr_clk);
      check(full == 1'b0, "R1", "full in reset", int'(full), 0);
      @(negedge rd_clk);
      check(empty == 1'b1, "R1", "empty in reset", int'(empty), 1);
      @(negedge wr_clk); wr_rst_n = 1'b1;
      @(negedge rd_clk); rd_rst_n = 1'b1;
      repeat (2) @(negedge wr_clk);
      check(full == 1'b0, "R1", "full after reset", int'(full), 0);
      @(negedge rd_clk);
      check(empty == 1'b1, "R1", "empty after reset", int'(empty), 1);
   endtask

   task automatic t_empty_latency();
      push(8'h5A);
      @(negedge rd_clk);
      check(empty == 1'b1, "R7", "empty held during sync", int'(empty), 1);
      pop("R5");
      check(empty == 1'b1, "R7", "empty right after last read", int'(empty), 1);
   endtask

   task automatic t_fill_overflow();
      int waited;
      for (int i = 0; i < DEPTH; i++) begin
         if (i == DEPTH - 1)
            check(full == 1'b0, "R3", "full before last slot", int'(full), 0);
         push(8'h10 + 8'(i));
      end
      check(full == 1'b1, "R3", "full after filling", int'(full), 1);
      @(negedge wr_clk);
      for (int i = 0; i < 3; i++) begin
         wr_en = 1'b1; wr_data = 8'hEE;
         @(negedge wr_clk);
      end
      wr_en = 1'b0;
      check(full == 1'b1, "R3", "full after dropped writes", int'(full), 1);
      for (int i = 0; i < DEPTH; i++) pop("R3");
      check(empty == 1'b1, "R7", "empty after drain", int'(empty), 1);
      waited = 0;
      while (full && waited < 12) begin
         @(negedge wr_clk);
         waited++;
      end
      check(full == 1'b0, "R8", "full cleared after drain", int'(full), 0);
   endtask

   task automatic t_underflow();
      logic [DATA_W-1:0] held;
      @(negedge rd_clk);
      held = rd_data;
      rd_en = 1'b1;
      repeat (3) @(negedge rd_clk);
      rd_en = 1'b0;
      check(rd_data == held, "R4", "rd_data held on empty read", int'(rd_data), int'(held));
      check(empty == 1'b1, "R4", "empty kept", int'(empty), 1);
      push(8'hC3);
      pop("R4");
   endtask

   task automatic t_random();
      int wn = 0;
      int rn = 0;
      fork
         begin
            while (wn < N_RAND) begin
               @(negedge wr_clk);
               if (!full && ($urandom % 3 != 0)) begin
                  wr_en = 1'b1; wr_data = 8'(wn * 7 + 3);
                  refq.push_back(wr_data);
                  wn++;
               end else begin
                  wr_en = 1'b0;
               end
            end
            @(negedge wr_clk);
            wr_en = 1'b0;
         end
         begin
            bit pend = 1'b0;
            while (rn < N_RAND || pend) begin
               @(negedge rd_clk);
               if (pend) begin
                  logic [DATA_W-1:0] exp;
                  if (refq.size() == 0) begin
                     check(1'b0, "R2", "read with nothing written", int'(rd_data), 0);
                  end else begin
                     exp = refq.pop_front();
                     check(rd_data == exp, "R2", "random order", int'(rd_data), int'(exp));
                  end
                  pend = 1'b0;
               end
               if (rn < N_RAND && !empty && ($urandom % 2 == 0)) begin
                  rd_en = 1'b1; pend = 1'b1; rn++;
               end else begin
                  rd_en = 1'b0;
               end
            end
            rd_en = 1'b0;
         end
      join
      repeat (4) @(negedge rd_clk);
      check(empty == 1'b1, "R2", "empty after random traffic", int'(empty), 1);
   endtask

   initial begin
      t_reset();
      t_empty_latency();
      t_fill_overflow();
      t_underflow();
      t_random();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge wr_clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL R2 watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule